// File: doc/BRIEF.md
# A/D Converter Control Register and Conversion Sequencer

This block is the digital front end of a successive-approximation analog-to-digital converter. Software reaches it through a small register bus. The block holds two byte-wide registers. The control register carries the conversion-clock source, the input channel, the start/busy flag and the module enable. The pin-setup register sets which of four pins are analog inputs and whether the highest pin serves as the external reference. From these fields the block drives the analog multiplexer select lines, a per-pin analog/digital mask and a reference-select line.

The block derives a conversion-clock enable. It takes either the system clock divided by one of three ratios, or the rising edges of a separate RC clock that arrives asynchronously and is synchronised inside the block. When software sets the start bit while the module is enabled, a sequencer issues a one-cycle start pulse to the converter datapath. It then holds the start bit at 1 until the datapath returns a done pulse, and at that point hardware clears the bit.

The sequencer has four states:
- **OFF**: the module is disabled.
- **IDLE**: the module is enabled and no conversion is running.
- **LAUNCH**: the single cycle in which the start pulse is driven.
- **WAIT**: a conversion is running.

Its transitions are:
- OFF→IDLE: enable written to 1.
- IDLE→LAUNCH: start bit written to 1.
- LAUNCH→WAIT: automatic on the next cycle.
- WAIT→IDLE: done pulse received.
- LAUNCH/WAIT→IDLE: software abort, by writing the start bit to 0.
- any→OFF: enable written to 0.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After reset every register field reads 0. conv_start and conv_clk_en are 0 and chan_sel is 0. Because pin-setup code 0 is the power-on value, pin_analog reads all ones and vref_ext reads 0.
- R2: Register map and read behaviour:
    - Address 0 is the control register: bits 7:6 clock source, bits 5:3 channel, bit 2 start/busy, bit 0 enable.
    - Address 1 is the pin-setup register, with its code in bits 1:0.
    - Control bit 1 and pin-setup bits 7:2 always read 0.
    - Any other address reads 0, and writes to it change nothing.
- R3: Writing the control register with bit 2 and bit 0 set, while the module is already enabled and idle, raises conv_start for exactly the one cycle after the write. Bit 2 then reads 1 until the conversion ends.
- R4: A conv_done pulse during a conversion clears bit 2 in the following cycle. A conv_done pulse while idle has no effect.
- R5: While the enable bit is 0, conv_clk_en stays 0, no conv_start is issued and writes of 1 to bit 2 are ignored, so bit 2 reads 0.
- R6: Writing 0 to the enable bit during a conversion aborts it, and bit 2 reads 0 from the next cycle.
- R7: Writing 0 to bit 2 during a conversion aborts it. A conv_done pulse arriving afterwards has no effect, and a later start works normally.
- R8: Clock-source codes 00, 01 and 10 give one conv_clk_en pulse every 2, 8 and 32 system-clock cycles respectively.
- R9: Clock-source code 11 gives one conv_clk_en pulse for each rising edge of rc_clk, after synchronisation.
- R10: A clock-source write made during a conversion reads back at once. The divider keeps its old ratio until the sequencer returns to idle.
- R11: chan_sel equals the two low bits of the channel field, so codes 4 to 7 select channels 0 to 3.
- R12: Pin-setup decode (bit i of pin_analog is pin i):

  | Code | pin_analog | vref_ext |
  |------|------------|----------|
  | 00   | 1111       | 0        |
  | 01   | 0111       | 1        |
  | 10   | 0011       | 1        |
  | 11   | 0000       | 0        |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rc_clk | input | 1 | Asynchronous RC clock for source code 11 |
| conv_done | input | 1 | Conversion-complete pulse from the datapath |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_clk_en | output | 1 | Conversion clock enable |
| chan_sel | output | CH_W | Analog multiplexer select |
| pin_analog | output | NUM_PINS | Per-pin analog (1) or digital (0) |
| vref_ext | output | 1 | Highest pin used as external reference |

## Verification
The bench builds the block with its default parameters: dividers of 2, 8 and 32, four channels, four pins and a two-stage synchroniser. With these values even the slowest divided period can be measured as a whole within a few dozen cycles. The bench also toggles rc_clk with a 14-cycle period that does not line up with the system clock edges, so the synchronised edge path yields a measurable, steady interval. Randomised writes sweep every channel code and pin-setup code. Directed sequences drive the abort paths and the deferred change of clock source.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        CK_DIV_A = 2'b00,
        CK_DIV_B = 2'b01,
        CK_DIV_C = 2'b10,
        CK_RC    = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        SEQ_OFF,
        SEQ_IDLE,
        SEQ_LAUNCH,
        SEQ_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        PC_ALL_ANALOG  = 2'b00,
        PC_EXT_REF     = 2'b01,
        PC_HALF_ANALOG = 2'b10,
        PC_ALL_DIGITAL = 2'b11
    } pin_cfg_e;

    localparam int SRC_HI  = 7;
    localparam int SRC_LO  = 6;
    localparam int CHAN_HI = 5;
    localparam int CHAN_LO = 3;
    localparam int GO_BIT  = 2;
    localparam int EN_BIT  = 0;

endpackage

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
    import adc_ctrl_pkg::*;
#(
    parameter int DIV_A       = 2,
    parameter int DIV_B       = 8,
    parameter int DIV_C       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     hold_sel,
    input  clk_src_e sel_req,
    input  logic     rc_clk,
    output logic     tick
);
    localparam int CNT_W = (DIV_C > 2) ? $clog2(DIV_C) : 1;

    clk_src_e                 sel_act;
    logic [CNT_W-1:0]         cnt;
    logic [CNT_W-1:0]         lim;
    logic                     sel_load;
    logic [SYNC_STAGES-1:0]   sync_q;
    logic                     rc_prev;
    logic                     rc_rise;

    // terminal count for the active division ratio
    always_comb begin
        unique case (sel_act)
            CK_DIV_A: lim = CNT_W'(DIV_A - 1);
            CK_DIV_B: lim = CNT_W'(DIV_B - 1);
            CK_DIV_C: lim = CNT_W'(DIV_C - 1);
            default:  lim = '0;
        endcase
    end

    // the source only changes while no conversion is running
    assign sel_load = !hold_sel && (sel_req != sel_act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_act <= CK_DIV_A;
        end else if (sel_load) begin
            sel_act <= sel_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || sel_load || cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // synchroniser chain for the asynchronous RC clock
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= rc_clk;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rc_prev <= 1'b0;
        else        rc_prev <= sync_q[SYNC_STAGES-1];
    end

    assign rc_rise = sync_q[SYNC_STAGES-1] & ~rc_prev;

    always_comb begin
        if (!run) begin
            tick = 1'b0;
        end else if (sel_act == CK_RC) begin
            tick = rc_rise;
        end else begin
            tick = (cnt == lim);
        end
    end

    p_sel_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_sel |=> $stable(sel_act))
        else $error("clock source changed during a conversion");

    p_tick_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("conversion clock enable held for two cycles");

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_next,
    input  logic go_set,
    input  logic go_clr,
    input  logic conv_done,
    output logic busy,
    output logic conv_start
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!en_next) begin
            state_nx = SEQ_OFF;
        end else begin
            unique case (state)
                SEQ_OFF:    state_nx = SEQ_IDLE;
                SEQ_IDLE:   state_nx = go_set ? SEQ_LAUNCH : SEQ_IDLE;
                SEQ_LAUNCH: state_nx = go_clr ? SEQ_IDLE : SEQ_WAIT;
                SEQ_WAIT:   state_nx = (go_clr || conv_done) ? SEQ_IDLE : SEQ_WAIT;
                default:    state_nx = SEQ_OFF;
            endcase
        end
    end

    always_comb begin
        busy       = 1'b0;
        conv_start = 1'b0;
        unique case (state)
            SEQ_LAUNCH: begin
                busy       = 1'b1;
                conv_start = 1'b1;
            end
            SEQ_WAIT:   busy = 1'b1;
            default:    ;
        endcase
    end

    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAIT && conv_done) |=> !busy)
        else $error("done pulse did not end the conversion");

    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start)
        else $error("start pulse longer than one cycle");

    p_disable_aborts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_next |=> (state == SEQ_OFF))
        else $error("sequencer still active after disable");

endmodule

// File: rtl/adc_pin_map.sv
module adc_pin_map
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  pin_cfg_e            cfg,
    output logic [NUM_PINS-1:0] pin_analog,
    output logic                vref_ext
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_comb begin
            unique case (cfg)
                PC_ALL_ANALOG:  pin_analog[i] = 1'b1;
                PC_EXT_REF:     pin_analog[i] = (i != NUM_PINS - 1);
                PC_HALF_ANALOG: pin_analog[i] = (i < NUM_PINS - 2);
                default:        pin_analog[i] = 1'b0;
            endcase
        end
    end

    assign vref_ext = (cfg == PC_EXT_REF) || (cfg == PC_HALF_ANALOG);

    always_comb begin
        assert (!(vref_ext && pin_analog[NUM_PINS-1]))
            else $error("p_ref_pin_not_input_r12: reference pin also an input");
    end

endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
    import adc_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int NUM_CH      = 4,
    parameter int NUM_PINS    = 4,
    parameter int DIV_A       = 2,
    parameter int DIV_B       = 8,
    parameter int DIV_C       = 32,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_we,
    output logic [7:0]          bus_rdata,
    input  logic                rc_clk,
    input  logic                conv_done,
    output logic                conv_start,
    output logic                conv_clk_en,
    output logic [CH_W-1:0]     chan_sel,
    output logic [NUM_PINS-1:0] pin_analog,
    output logic                vref_ext
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] PCFG_ADDR = ADDR_W'(1);
    localparam int CHAN_W = CHAN_HI - CHAN_LO + 1;

    logic [1:0]        src_q;
    logic [CHAN_W-1:0] chan_q;
    logic              en_q;
    logic [1:0]        pcfg_q;
    logic              ctrl_wr, pcfg_wr;
    logic              en_next, go_set, go_clr;
    logic              busy;

    assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);
    assign pcfg_wr = bus_we && (bus_addr == PCFG_ADDR);
    assign en_next = ctrl_wr ? bus_wdata[EN_BIT] : en_q;
    assign go_set  = ctrl_wr &&  bus_wdata[GO_BIT];
    assign go_clr  = ctrl_wr && !bus_wdata[GO_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            chan_q <= '0;
            en_q   <= 1'b0;
        end else if (ctrl_wr) begin
            src_q  <= bus_wdata[SRC_HI:SRC_LO];
            chan_q <= bus_wdata[CHAN_HI:CHAN_LO];
            en_q   <= bus_wdata[EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       pcfg_q <= '0;
        else if (pcfg_wr) pcfg_q <= bus_wdata[1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[SRC_HI:SRC_LO]   = src_q;
            bus_rdata[CHAN_HI:CHAN_LO] = chan_q;
            bus_rdata[GO_BIT]          = busy;
            bus_rdata[EN_BIT]          = en_q;
        end else if (bus_addr == PCFG_ADDR) begin
            bus_rdata[1:0] = pcfg_q;
        end
    end

    assign chan_sel = chan_q[CH_W-1:0];

    adc_conv_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_next    (en_next),
        .go_set     (go_set),
        .go_clr     (go_clr),
        .conv_done  (conv_done),
        .busy       (busy),
        .conv_start (conv_start)
    );

    adc_clk_prescaler #(
        .DIV_A       (DIV_A),
        .DIV_B       (DIV_B),
        .DIV_C       (DIV_C),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .hold_sel (busy),
        .sel_req  (clk_src_e'(src_q)),
        .rc_clk   (rc_clk),
        .tick     (conv_clk_en)
    );

    adc_pin_map #(
        .NUM_PINS (NUM_PINS)
    ) u_pins (
        .cfg        (pin_cfg_e'(pcfg_q)),
        .pin_analog (pin_analog),
        .vref_ext   (vref_ext)
    );

    p_busy_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !busy)
        else $error("conversion active while disabled");

    p_no_tick_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !conv_clk_en)
        else $error("conversion clock running while disabled");

    p_start_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> en_q)
        else $error("start issued without enable");

    p_sw_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_clr) |=> !busy)
        else $error("software abort ignored");

endmodule

// File: tb/adc_ctrl_seq_test.sv
module adc_ctrl_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       rc_clk = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_start, conv_clk_en, vref_ext;
    logic [1:0] chan_sel;
    logic [3:0] pin_analog;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;
    always #70 rc_clk = ~rc_clk;

    adc_ctrl_seq uut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_we (bus_we), .bus_rdata (bus_rdata), .rc_clk (rc_clk),
        .conv_done (conv_done), .conv_start (conv_start), .conv_clk_en (conv_clk_en),
        .chan_sel (chan_sel), .pin_analog (pin_analog), .vref_ext (vref_ext)
    );

    function automatic logic [3:0] exp_pins(input logic [1:0] c);
        case (c)
            2'b00:   return 4'b1111;
            2'b01:   return 4'b0111;
            2'b10:   return 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int exp_period(input logic [1:0] s);
        case (s)
            2'b00:   return 2;
            2'b01:   return 8;
            2'b10:   return 32;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] ctrl_word(input logic [1:0] s, input logic [2:0] ch,
                                             input logic go, input logic en);
        return {s, ch, go, 1'b0, en};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic measure(output int per);
        int guard = 0;
        while (!conv_clk_en && guard < 400) begin @(negedge clk); guard++; end
        @(negedge clk);
        per = 1;
        while (!conv_clk_en && per < 400) begin @(negedge clk); per++; end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int per;
        int ticks;
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); check(rd == 8'h00, "R1 ctrl reset", rd, 0);
        bus_read(2'd1, rd); check(rd == 8'h00, "R1 pcfg reset", rd, 0);
        check(pin_analog == 4'b1111 && !vref_ext, "R1 pins reset", pin_analog, 4'hf);
        check(!conv_start && !conv_clk_en && chan_sel == 2'd0, "R1 outputs idle",
              {conv_start, conv_clk_en, chan_sel}, 0);

        // R5 disabled: no ticks, go ignored
        ticks = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (conv_clk_en) ticks++; end
        check(ticks == 0, "R5 no tick while off", ticks, 0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] w;
            w = ctrl_word(2'($urandom), 3'($urandom), 1'b1, 1'b0);
            bus_write(2'd0, w);
            check(!conv_start, "R5 no start while off", conv_start, 0);
            bus_read(2'd0, rd);
            check(rd == (w & 8'hf9), "R5 go ignored", rd, w & 8'hf9);
        end

        // R12 / R2 random pin-setup writes
        for (int i = 0; i < 16; i++) begin
            logic [7:0] w;
            w = 8'($urandom);
            bus_write(2'd1, w);
            check(pin_analog == exp_pins(w[1:0]), "R12 pin mask", pin_analog, exp_pins(w[1:0]));
            check(vref_ext == (w[1:0] == 2'b01 || w[1:0] == 2'b10), "R12 vref",
                  vref_ext, (w[1:0] == 2'b01 || w[1:0] == 2'b10));
            bus_read(2'd1, rd);
            check(rd == {6'b0, w[1:0]}, "R2 pcfg readback", rd, {6'b0, w[1:0]});
        end

        // R11 channel aliasing, R2 control readback
        for (int i = 0; i < 16; i++) begin
            logic [7:0] w;
            w = ctrl_word(2'($urandom), 3'(i), 1'b0, 1'b1);
            bus_write(2'd0, w);
            check(chan_sel == 2'(i), "R11 channel alias", chan_sel, i % 4);
            bus_read(2'd0, rd);
            check(rd == w, "R2 ctrl readback", rd, w);
        end

        // R2 unused addresses
        bus_write(2'd1, 8'h02);
        bus_write(2'd0, ctrl_word(2'b01, 3'd5, 1'b0, 1'b1));
        for (int i = 0; i < 6; i++) begin
            logic [1:0] a;
            a = 2'd2 + 2'(i % 2);
            bus_write(a, 8'($urandom));
            bus_read(a, rd); check(rd == 8'h00, "R2 unused reads 0", rd, 0);
        end
        bus_read(2'd0, rd);
        check(rd == ctrl_word(2'b01, 3'd5, 1'b0, 1'b1), "R2 ctrl untouched", rd, 8'h69);
        bus_read(2'd1, rd); check(rd == 8'h02, "R2 pcfg untouched", rd, 2);

        // R8 / R9 periods per source
        for (int s = 0; s < 4; s++) begin
            bus_write(2'd0, ctrl_word(2'(s), 3'd0, 1'b0, 1'b1));
            measure(per);
            measure(per);
            check(per == exp_period(2'(s)), s == 3 ? "R9 rc period" : "R8 div period",
                  per, exp_period(2'(s)));
        end

        // R3 / R4 start and done
        bus_write(2'd0, ctrl_word(2'b00, 3'd2, 1'b0, 1'b1));
        bus_write(2'd0, ctrl_word(2'b00, 3'd2, 1'b1, 1'b1));
        check(conv_start, "R3 start pulse", conv_start, 1);
        bus_read(2'd0, rd); check(rd[2], "R3 busy reads 1", rd[2], 1);
        @(negedge clk);
        check(!conv_start, "R3 start one cycle", conv_start, 0);
        repeat (5) @(negedge clk);
        bus_read(2'd0, rd); check(rd[2], "R3 busy held", rd[2], 1);

        // R10 deferred source change
        bus_write(2'd0, ctrl_word(2'b10, 3'd2, 1'b1, 1'b1));
        bus_read(2'd0, rd); check(rd[7:6] == 2'b10, "R10 src readback", rd[7:6], 2);
        measure(per); measure(per);
        check(per == 2, "R10 old ratio kept", per, 2);
        pulse_done();
        bus_read(2'd0, rd); check(!rd[2], "R4 done clears go", rd[2], 0);
        measure(per); measure(per);
        check(per == 32, "R10 new ratio after idle", per, 32);
        pulse_done();
        bus_read(2'd0, rd); check(rd == ctrl_word(2'b10, 3'd2, 1'b0, 1'b1),
                                  "R4 done while idle no effect", rd, 8'h91);

        // R7 software abort
        bus_write(2'd0, ctrl_word(2'b00, 3'd1, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        bus_write(2'd0, ctrl_word(2'b00, 3'd1, 1'b0, 1'b1));
        bus_read(2'd0, rd); check(!rd[2], "R7 abort clears go", rd[2], 0);
        pulse_done();
        bus_read(2'd0, rd); check(!rd[2] && !conv_start, "R7 late done ignored", rd, 8'h09);
        bus_write(2'd0, ctrl_word(2'b00, 3'd1, 1'b1, 1'b1));
        check(conv_start, "R7 restart after abort", conv_start, 1);

        // R6 disable abort
        repeat (2) @(negedge clk);
        bus_write(2'd0, ctrl_word(2'b00, 3'd1, 1'b1, 1'b0));
        bus_read(2'd0, rd); check(rd[2] == 1'b0 && rd[0] == 1'b0, "R6 disable aborts", rd, 8'h08);
        @(negedge clk);
        check(!conv_clk_en, "R6 clock stopped", conv_clk_en, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule